// File: doc/BRIEF.md
# Token-Based Completion Buffer

This block restores issue order for work that finishes out of order. A client asks for a token, which is a slot index into a circular store. It starts its work and later deposits the result under that token. A consumer then takes the results out strictly in the order the tokens were granted. It does not matter in which order the results were deposited.

Three operations can occur in one cycle, and they take effect in a fixed logical sequence: the token grant first, then the deposit, then the drain. Because of this, a result deposited into the oldest outstanding slot can leave in the same cycle. At an empty buffer, one cycle can grant a token, fill that slot and drain it. The occupancy count adds the grant and subtracts the drain in a single update.

Top module: `reorder_slot_buffer`

## Requirements
- R1: After reset every slot is empty, no token is outstanding, `tok_avail` is 1, `tok_idx` is 0 and `res_avail` is 0.
- R2: `tok_avail` is 0 exactly when DEPTH tokens are outstanding (granted and not yet drained). A `tok_take` while `tok_avail` is 0 grants nothing.
- R3: `tok_idx` shows the insert index, which is the slot the next grant returns. It starts at 0 and advances by one per grant, wrapping from DEPTH-1 to 0. With DEPTH 16 the index is 4 bits.
- R4: A deposit (`put_en`, `put_idx`, `put_data`) stores the data in slot `put_idx` and marks it full. Results leave in grant order whatever the deposit order was.
- R5: `res_avail` is 1 only when at least one token is outstanding (counting a grant in the same cycle) and the slot at the remove index is full. A `res_take` while `res_avail` is 0 drains nothing.
- R6: In one cycle the grant acts before the deposit, and the deposit acts before the drain. A deposit to the oldest slot is visible on `res_avail`/`res_data` in that same cycle, and grant, deposit and drain of one slot can all happen in one cycle.
- R7: A grant and a drain in the same cycle leave the number of outstanding tokens unchanged.
- R8: A grant empties its slot. A reissued slot never yields stale data and is not drainable until it receives a new deposit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_take | input | 1 | Client takes the offered token |
| tok_avail | output | 1 | A token can be granted this cycle |
| tok_idx | output | IDX_W | Index of the token on offer |
| put_en | input | 1 | Deposit a result |
| put_idx | input | IDX_W | Token the result belongs to |
| put_data | input | DATA_W | Result data |
| res_take | input | 1 | Consumer takes the head result |
| res_avail | output | 1 | Head result is ready |
| res_data | output | DATA_W | Head result data |

## Verification
The bench aims at the same-cycle orderings. A deposit to the head slot that does not appear until the next cycle shows up as a missing `res_avail`. A grant that clears the head after the deposit, instead of before it, loses the pass-through at an empty buffer. A grant and a drain in the same cycle that do not net out leave `tok_avail` wrong once the buffer is one grant from full. The bench also reissues slots after wraparound, where a stale full flag would release old data, and it fills the buffer to capacity, where a wrong full test would hand out a slot that is still occupied.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    // Width of a slot index for a store of the given depth.
    function automatic int unsigned idx_width(int unsigned depth);
        return (depth <= 1) ? 1 : $clog2(depth);
    endfunction

    // Width of an occupancy count that must reach the depth itself.
    function automatic int unsigned cnt_width(int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    // Operations that fire in one cycle, in their logical order.
    typedef struct packed {
        logic grant;
        logic deposit;
        logic drain;
    } rsb_ops_t;

endpackage

// File: rtl/rsb_ring_index.sv
module rsb_ring_index #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IW = rsb_pkg::idx_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [IW-1:0] idx_q
);
    typedef struct packed {
        logic [IW-1:0] idx;
    } ring_t;

    ring_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.idx == IW'(DEPTH - 1)) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q = st_q.idx;
endmodule

// File: rtl/rsb_occupancy.sv
module rsb_occupancy #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = rsb_pkg::cnt_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt_q,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } occ_t;

    occ_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({inc, dec})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/rsb_slot_store.sv
module rsb_slot_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IW = rsb_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rsb_pkg::rsb_ops_t ops,
    input  logic [IW-1:0]     clr_idx,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic              head_vld,
    output logic [DATA_W-1:0] head_data
);
    // Full flag of each slot after grant and deposit, before drain.
    logic [DEPTH-1:0] mid_vld;
    logic [DEPTH-1:0] vld_d, vld_q;
    logic [DATA_W-1:0] dat_d [DEPTH];
    logic [DATA_W-1:0] dat_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            mid_vld[i] = vld_q[i];
            dat_d[i]   = dat_q[i];
            if (ops.grant && clr_idx == IW'(i)) begin
                mid_vld[i] = 1'b0;
            end
            if (ops.deposit && wr_idx == IW'(i)) begin
                mid_vld[i] = 1'b1;
                dat_d[i]   = wr_data;
            end
            vld_d[i] = mid_vld[i];
            if (ops.drain && rd_idx == IW'(i)) begin
                vld_d[i] = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                dat_q[i] <= '0;
            end else begin
                vld_q[i] <= vld_d[i];
                dat_q[i] <= dat_d[i];
            end
        end
    end

    assign head_vld  = mid_vld[rd_idx];
    assign head_data = dat_d[rd_idx];
endmodule

// File: rtl/reorder_slot_buffer.sv
module reorder_slot_buffer #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = rsb_pkg::idx_width(DEPTH),
    localparam int unsigned CW    = rsb_pkg::cnt_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_take,
    output logic              tok_avail,
    output logic [IDX_W-1:0]  tok_idx,
    input  logic              put_en,
    input  logic [IDX_W-1:0]  put_idx,
    input  logic [DATA_W-1:0] put_data,
    input  logic              res_take,
    output logic              res_avail,
    output logic [DATA_W-1:0] res_data
);
    rsb_pkg::rsb_ops_t ops;
    logic [IDX_W-1:0]  ins_idx_q, rem_idx_q;
    logic [CW-1:0]     cnt_q;
    logic              full, empty;
    logic              head_vld;
    logic [DATA_W-1:0] head_data;

    // Grant first, then deposit, then drain.
    always_comb begin
        ops.grant   = tok_take && !full;
        ops.deposit = put_en;
        ops.drain   = res_take && res_avail;
    end

    assign tok_avail = !full;
    assign tok_idx   = ins_idx_q;
    assign res_avail = (!empty || ops.grant) && head_vld;
    assign res_data  = head_data;

    rsb_ring_index #(.DEPTH(DEPTH)) u_ins (
        .clk(clk), .rst_n(rst_n), .adv(ops.grant), .idx_q(ins_idx_q)
    );

    rsb_ring_index #(.DEPTH(DEPTH)) u_rem (
        .clk(clk), .rst_n(rst_n), .adv(ops.drain), .idx_q(rem_idx_q)
    );

    rsb_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .inc(ops.grant), .dec(ops.drain),
        .cnt_q(cnt_q), .full(full), .empty(empty)
    );

    rsb_slot_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .ops(ops),
        .clr_idx(ins_idx_q), .wr_idx(put_idx), .wr_data(put_data),
        .rd_idx(rem_idx_q), .head_vld(head_vld), .head_data(head_data)
    );
endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned CW     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tok_take,
    input logic             tok_avail,
    input logic [IDX_W-1:0] tok_idx,
    input logic             put_en,
    input logic [IDX_W-1:0] put_idx,
    input logic             res_take,
    input logic             res_avail,
    input logic [CW-1:0]    cnt_q,
    input logic [IDX_W-1:0] rem_idx_q
);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R2
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(DEPTH)) |-> !tok_avail);

    // R3
    tok_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_avail && tok_take) |=>
        tok_idx == (($past(tok_idx) == IDX_W'(DEPTH - 1)) ? '0 : $past(tok_idx) + 1'b1));

    // R5
    res_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_avail |-> (cnt_q != '0 || (tok_avail && tok_take)));

    // R7
    balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_avail && tok_take && res_avail && res_take) |=> cnt_q == $past(cnt_q));

    // R4
    deposit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (put_en && cnt_q != '0 && put_idx == rem_idx_q && !res_take) |=> res_avail);
endmodule

bind reorder_slot_buffer rsb_checker #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CW(CW)
) u_rsb_chk (
    .clk(clk), .rst_n(rst_n), .tok_take(tok_take), .tok_avail(tok_avail),
    .tok_idx(tok_idx), .put_en(put_en), .put_idx(put_idx), .res_take(res_take),
    .res_avail(res_avail), .cnt_q(cnt_q), .rem_idx_q(rem_idx_q)
);

// File: tb/reorder_slot_buffer_bench.sv
module reorder_slot_buffer_bench;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 32;
    localparam int IW     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_take = 1'b0, put_en = 1'b0, res_take = 1'b0;
    logic [IW-1:0] put_idx = '0;
    logic [DATA_W-1:0] put_data = '0;
    logic tok_avail, res_avail;
    logic [IW-1:0] tok_idx;
    logic [DATA_W-1:0] res_data;

    int checks = 0, failures = 0;
    bit done = 0;

    // Reference state, built from the requirements.
    int m_cnt = 0, m_wr = 0, m_rd = 0;
    bit m_val [DEPTH];
    logic [DATA_W-1:0] m_dat [DEPTH];

    always #4 clk = ~clk;   // 125 MHz

    reorder_slot_buffer u_reorder_slot_buffer (
        .clk(clk), .rst_n(rst_n), .tok_take(tok_take), .tok_avail(tok_avail),
        .tok_idx(tok_idx), .put_en(put_en), .put_idx(put_idx), .put_data(put_data),
        .res_take(res_take), .res_avail(res_avail), .res_data(res_data)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check, then commit at the rising edge.
    task automatic step(bit t, bit p, int pidx, logic [DATA_W-1:0] pd, bit r);
        bit tokf, vh, era;
        logic [DATA_W-1:0] ed;
        @(negedge clk);
        tok_take = t; put_en = p; put_idx = IW'(pidx); put_data = pd; res_take = r;
        #1;
        tokf = t && (m_cnt != DEPTH);
        vh = m_val[m_rd];
        if (tokf && m_wr == m_rd) vh = 0;
        if (p && pidx == m_rd) vh = 1;
        era = (m_cnt != 0 || tokf) && vh;
        ed = (p && pidx == m_rd) ? pd : m_dat[m_rd];
        check("R2 tok_avail", 64'(tok_avail), 64'(m_cnt != DEPTH));
        check("R3 tok_idx", 64'(tok_idx), 64'(m_wr));
        check("R5 res_avail", 64'(res_avail), 64'(era));
        if (era) check((p && pidx == m_rd) ? "R6 res_data" : "R4 res_data",
                       64'(res_data), 64'(ed));
        if (tokf) begin m_val[m_wr] = 0; m_wr = (m_wr + 1) % DEPTH; end
        if (p) begin m_val[pidx] = 1; m_dat[pidx] = pd; end
        if (r && era) begin m_val[m_rd] = 0; m_rd = (m_rd + 1) % DEPTH; end
        m_cnt = m_cnt + (tokf ? 1 : 0) - ((r && era) ? 1 : 0);
        @(posedge clk);
    endtask

    task automatic drain_all();
        for (int k = 0; k < 200 && m_cnt != 0; k++) begin
            int c;
            c = -1;
            for (int j = 0; j < m_cnt; j++)
                if (c < 0 && !m_val[(m_rd + j) % DEPTH]) c = (m_rd + j) % DEPTH;
            if (c >= 0) step(0, 1, c, $urandom, 1);
            else step(0, 0, 0, '0, 1);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin m_val[i] = 0; m_dat[i] = '0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tok_avail", 64'(tok_avail), 64'd1);
        check("R1 tok_idx", 64'(tok_idx), 64'd0);
        check("R1 res_avail", 64'(res_avail), 64'd0);

        // R6 grant, deposit and drain of one slot in one cycle
        step(1, 1, 0, 32'hA5A5_0001, 1);
        check("R6 passthrough left empty", 64'(m_cnt), 64'd0);

        // R4 out-of-order deposits, in-order results
        step(1, 0, 0, '0, 0); step(1, 0, 0, '0, 0); step(1, 0, 0, '0, 0);
        step(0, 1, 3, 32'h3333, 1);
        step(0, 1, 2, 32'h2222, 1);
        step(0, 1, 1, 32'h1111, 1);
        step(0, 0, 0, '0, 1); step(0, 0, 0, '0, 1); step(0, 0, 0, '0, 1);

        // R7 grant plus drain one short of full, then fill
        for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, '0, 0);
        step(1, 1, m_rd, 32'h7777, 1);
        step(1, 0, 0, '0, 0);
        @(negedge clk); #1;
        check("R7 full after balanced cycle", 64'(tok_avail), 64'd0);
        // R2 take while full is ignored
        step(1, 0, 0, '0, 0);
        check("R2 no grant when full", 64'(m_cnt), 64'(DEPTH));
        drain_all();

        // R8 reissued slots hold no stale data
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 0, 0, '0, 1);
            check("R8 reissued slot not ready", 64'(res_avail), 64'd0);
        end
        drain_all();

        // Random mix with changing drain pressure
        for (int n = 0; n < 3000; n++) begin
            bit t, p, r;
            int cand [DEPTH + 1];
            int nc, pidx;
            t = ($urandom % 4) != 0;
            r = ($urandom % 8) < ((n / 500) % 2 == 0 ? 2 : 6);
            nc = 0;
            for (int j = 0; j < m_cnt; j++)
                if (!m_val[(m_rd + j) % DEPTH]) begin cand[nc] = (m_rd + j) % DEPTH; nc++; end
            if (t && m_cnt != DEPTH) begin cand[nc] = m_wr; nc++; end
            p = (nc > 0) && (($urandom % 3) != 0);
            pidx = (nc > 0) ? cand[$urandom % nc] : 0;
            step(t, p, pidx, $urandom, r);
        end
        drain_all();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule